// File: doc/BRIEF.md
# Virtual Interrupt Pending and Status Logic

This block sits beside a processor core's exception logic and works out which virtual interrupts are pending for a guest. It holds a small hypervisor extension control register and the all-interrupt mask bit (ALLINT) of the processor state. From these, the hypervisor's routing and injection bits, and the interrupt controller's lines, it derives four pending levels: virtual IRQ, virtual FIQ, and the superpriority (non-maskable) forms of each. Two extension bits steer the hypervisor's IRQ and FIQ injection bits to either the normal line or the superpriority line.

A simple register port reads and writes the extension register and ALLINT, and reads a status word. Each access carries the current exception level. A write that sets ALLINT from level 1 while the trap-enable bit is set raises a trap toward level 2. An ALLINT write from level 0 is flagged as illegal. The status word reports pending IRQ and FIQ, and flags superpriority in separate bits. Whether it reports virtual or physical sources depends on the hypervisor's routing bits. The superpriority feature is a parameter. Without it, the extension register reads as zero and ALLINT is absent.

Top module: `virt_irq_status`

## Requirements
- R1: While reset is asserted and after it is released, the extension register and ALLINT read zero. No virtual interrupt is pending unless an external line is high.
- R2: virqPend = (hypVi AND NOT irq-steer bit) OR extVirq.
- R3: vfiqPend = (hypVf AND NOT fiq-steer bit) OR extVfiq.
- R4: vinmiPend = (hypVi AND irq-steer bit) OR extVinmi.
- R5: vfnmiPend = hypVf AND fiq-steer bit. There is no external line for it.
- R6: The extension register (regSel 0) has bit 0 trap-enable, bit 1 irq-steer and bit 2 fiq-steer. A write keeps only these three bits when HAS_NMI=1 and keeps none when HAS_NMI=0. All other bits read zero.
- R7: The pending outputs follow input line changes in the same cycle. They reflect a register write from the first cycle after the write's clock edge.
- R8: Status bit 7 (I) is (virqPend OR vinmiPend) when hypImo=1, else (physIrq OR physNmi). Status bit 10 (IS) is vinmiPend when hypImo=1, else physNmi.
- R9: Status bit 6 (F) is (vfiqPend OR vfnmiPend) when hypFmo=1, else physFiq. Status bit 9 (FS) is vfnmiPend when hypFmo=1, else 0. All other status bits are zero.
- R10: ALLINT is read and written at bit 13 through regSel 1, from levels 1 to 3. When HAS_NMI=0 it reads zero and writes are ignored.
- R11: An ALLINT write from level 1 with bit 13 set, while trap-enable is set, drives trapOut high in that cycle and leaves ALLINT unchanged. Writes that clear ALLINT, and all reads, are never trapped.
- R12: An ALLINT write from level 0 drives illegalOut high in that cycle and leaves ALLINT unchanged.
- R13: The status word (regSel 2) is read-only. Writes to it change nothing. regSel 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 extension, 1 ALLINT, 2 status, 3 none |
| wrData | input | DATA_W | Write data |
| curLevel | input | 2 | Exception level of the access |
| hypImo | input | 1 | Hypervisor routes IRQ to virtual |
| hypFmo | input | 1 | Hypervisor routes FIQ to virtual |
| hypVi | input | 1 | Hypervisor virtual IRQ injection bit |
| hypVf | input | 1 | Hypervisor virtual FIQ injection bit |
| extVirq | input | 1 | Controller virtual IRQ line |
| extVfiq | input | 1 | Controller virtual FIQ line |
| extVinmi | input | 1 | Controller virtual superpriority IRQ line |
| physIrq | input | 1 | Physical IRQ line |
| physFiq | input | 1 | Physical FIQ line |
| physNmi | input | 1 | Physical superpriority IRQ line |
| regRdData | output | DATA_W | Read data for regSel |
| statusWord | output | DATA_W | Interrupt status word |
| virqPend | output | 1 | Virtual IRQ pending |
| vfiqPend | output | 1 | Virtual FIQ pending |
| vinmiPend | output | 1 | Virtual superpriority IRQ pending |
| vfnmiPend | output | 1 | Virtual superpriority FIQ pending |
| trapOut | output | 1 | ALLINT write trapped to level 2 |
| illegalOut | output | 1 | ALLINT write from level 0 |

## Verification
The bench builds two copies side by side with DATA_W=64: one with HAS_NMI=1 and one with HAS_NMI=0. Both get the same stimulus and are compared against a behavioural model on every cycle. The first copy covers superpriority steering, the trap and illegal paths, and every combination of routing and line inputs under each of the eight extension values. The second shows that the same writes leave the extension register and ALLINT at zero, and that no trap or illegal flag is ever raised.

// File: rtl/virt_irq_pkg.sv
package virt_irq_pkg;
  typedef enum logic [1:0] {
    SEL_EXT    = 2'd0,
    SEL_ALLINT = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // extension register field positions
  localparam int EXT_TRAP_BIT   = 0;
  localparam int EXT_IRQSEL_BIT = 1;
  localparam int EXT_FIQSEL_BIT = 2;
  localparam int EXT_BITS       = 3;

  // processor-state and status word positions
  localparam int ALLINT_BIT = 13;
  localparam int IS_BIT     = 10;
  localparam int FS_BIT     = 9;
  localparam int I_BIT      = 7;
  localparam int F_BIT      = 6;

  typedef struct packed {
    logic extWr;
    logic allintWr;
    logic allintVal;
    logic trap;
    logic illegal;
  } ctrlStrobe_t;
endpackage

// File: rtl/virt_irq_ctrl.sv
module virt_irq_ctrl
  import virt_irq_pkg::*;
#(
  parameter bit HAS_NMI = 1'b1
) (
  input  logic        wrEn,
  input  logic [1:0]  regSel,
  input  logic [1:0]  curLevel,
  input  logic        allintBit,
  input  logic        trapEn,
  output ctrlStrobe_t strb
);
  regSel_e selDec;
  logic    isAllintWr;
  logic    unusedCtrl;

  assign selDec     = regSel_e'(regSel);
  assign isAllintWr = wrEn && (selDec == SEL_ALLINT);
  assign unusedCtrl = ^{curLevel, allintBit, trapEn, isAllintWr};

  generate
    if (HAS_NMI) begin : g_nmi
      logic fromLevel0;
      logic fromLevel1;
      always_comb begin
        fromLevel0     = (curLevel == 2'd0);
        fromLevel1     = (curLevel == 2'd1);
        strb.extWr     = wrEn && (selDec == SEL_EXT);
        strb.illegal   = isAllintWr && fromLevel0;
        // only setting is trapped; clearing always goes through
        strb.trap      = isAllintWr && fromLevel1 && trapEn && allintBit;
        strb.allintWr  = isAllintWr && !strb.illegal && !strb.trap;
        strb.allintVal = allintBit;
      end
    end else begin : g_plain
      always_comb begin
        strb.extWr     = wrEn && (selDec == SEL_EXT);
        strb.illegal   = 1'b0;
        strb.trap      = 1'b0;
        strb.allintWr  = 1'b0;
        strb.allintVal = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/virt_irq_dp.sv
module virt_irq_dp
  import virt_irq_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit HAS_NMI = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [EXT_BITS-1:0] extWrBits,
  input  logic [1:0]          regSel,
  input  logic                hypImo,
  input  logic                hypFmo,
  input  logic                hypVi,
  input  logic                hypVf,
  input  logic                extVirq,
  input  logic                extVfiq,
  input  logic                extVinmi,
  input  logic                physIrq,
  input  logic                physFiq,
  input  logic                physNmi,
  output logic                virqPend,
  output logic                vfiqPend,
  output logic                vinmiPend,
  output logic                vfnmiPend,
  output logic [DATA_W-1:0]   statusWord,
  output logic [DATA_W-1:0]   regRdData,
  output logic                trapEn,
  output logic                allintState
);
  localparam logic [EXT_BITS-1:0] EXT_MASK = HAS_NMI ? {EXT_BITS{1'b1}} : {EXT_BITS{1'b0}};

  logic [EXT_BITS-1:0] extReg;
  logic                allintQ;
  logic                irqSteer;
  logic                fiqSteer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extReg <= '0;
    end else if (strb.extWr) begin
      extReg <= extWrBits & EXT_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      allintQ <= 1'b0;
    end else if (strb.allintWr) begin
      allintQ <= strb.allintVal;
    end
  end

  assign irqSteer    = extReg[EXT_IRQSEL_BIT];
  assign fiqSteer    = extReg[EXT_FIQSEL_BIT];
  assign trapEn      = extReg[EXT_TRAP_BIT];
  assign allintState = allintQ;

  // injection bits go to either the normal or the superpriority line
  always_comb begin
    virqPend  = (hypVi && !irqSteer) || extVirq;
    vinmiPend = (hypVi &&  irqSteer) || extVinmi;
    vfiqPend  = (hypVf && !fiqSteer) || extVfiq;
    vfnmiPend =  hypVf &&  fiqSteer;
  end

  always_comb begin
    statusWord = '0;
    if (hypImo) begin
      statusWord[I_BIT]  = virqPend || vinmiPend;
      statusWord[IS_BIT] = vinmiPend;
    end else begin
      statusWord[I_BIT]  = physIrq || physNmi;
      statusWord[IS_BIT] = physNmi;
    end
    if (hypFmo) begin
      statusWord[F_BIT]  = vfiqPend || vfnmiPend;
      statusWord[FS_BIT] = vfnmiPend;
    end else begin
      statusWord[F_BIT]  = physFiq;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regSel_e'(regSel))
      SEL_EXT:    regRdData[EXT_BITS-1:0] = extReg;
      SEL_ALLINT: regRdData[ALLINT_BIT]   = allintQ;
      SEL_STATUS: regRdData               = statusWord;
      default:    regRdData               = '0;
    endcase
  end
endmodule

// File: rtl/virt_irq_status.sv
module virt_irq_status
  import virt_irq_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit HAS_NMI = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        curLevel,
  input  logic              hypImo,
  input  logic              hypFmo,
  input  logic              hypVi,
  input  logic              hypVf,
  input  logic              extVirq,
  input  logic              extVfiq,
  input  logic              extVinmi,
  input  logic              physIrq,
  input  logic              physFiq,
  input  logic              physNmi,
  output logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-1:0] statusWord,
  output logic              virqPend,
  output logic              vfiqPend,
  output logic              vinmiPend,
  output logic              vfnmiPend,
  output logic              trapOut,
  output logic              illegalOut
);
  ctrlStrobe_t strb;
  logic        trapEn;
  logic        allintState;
  logic        unusedWrBits;

  assign unusedWrBits = ^wrData;

  virt_irq_ctrl #(.HAS_NMI(HAS_NMI)) ctrl_i (
    .wrEn      (wrEn),
    .regSel    (regSel),
    .curLevel  (curLevel),
    .allintBit (wrData[ALLINT_BIT]),
    .trapEn    (trapEn),
    .strb      (strb)
  );

  virt_irq_dp #(.DATA_W(DATA_W), .HAS_NMI(HAS_NMI)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .extWrBits   (wrData[EXT_BITS-1:0]),
    .regSel      (regSel),
    .hypImo      (hypImo),
    .hypFmo      (hypFmo),
    .hypVi       (hypVi),
    .hypVf       (hypVf),
    .extVirq     (extVirq),
    .extVfiq     (extVfiq),
    .extVinmi    (extVinmi),
    .physIrq     (physIrq),
    .physFiq     (physFiq),
    .physNmi     (physNmi),
    .virqPend    (virqPend),
    .vfiqPend    (vfiqPend),
    .vinmiPend   (vinmiPend),
    .vfnmiPend   (vfnmiPend),
    .statusWord  (statusWord),
    .regRdData   (regRdData),
    .trapEn      (trapEn),
    .allintState (allintState)
  );

  assign trapOut    = strb.trap;
  assign illegalOut = strb.illegal;
endmodule

// File: rtl/virt_irq_status_chk.sv
module virt_irq_status_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regSel,
  input logic [DATA_W-1:0] wrData,
  input logic [1:0]        curLevel,
  input logic              hypVf,
  input logic              extVirq,
  input logic              extVinmi,
  input logic [DATA_W-1:0] regRdData,
  input logic [DATA_W-1:0] statusWord,
  input logic              virqPend,
  input logic              vinmiPend,
  input logic              vfnmiPend,
  input logic              trapOut,
  input logic              illegalOut,
  input logic              allintState
);
  // R11
  trap_keeps_allint_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |=> $stable(allintState));

  // R11
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> (wrEn && regSel == 2'd1 && curLevel == 2'd1 && wrData[13]));

  // R12
  illegal_keeps_allint_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |=> $stable(allintState));

  // R5
  vfnmi_needs_inject_chk: assert property (@(posedge clk) disable iff (!rstN)
    vfnmiPend |-> hypVf);

  // R4
  irq_steer_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!extVirq && !extVinmi) |-> !(virqPend && vinmiPend));

  // R8
  is_implies_i_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[10] |-> statusWord[7]);

  // R9
  fs_implies_f_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[9] |-> statusWord[6]);

  // R6
  ext_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd0) |-> (regRdData[DATA_W-1:3] == '0));
endmodule

bind virt_irq_status virt_irq_status_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .regSel      (regSel),
  .wrData      (wrData),
  .curLevel    (curLevel),
  .hypVf       (hypVf),
  .extVirq     (extVirq),
  .extVinmi    (extVinmi),
  .regRdData   (regRdData),
  .statusWord  (statusWord),
  .virqPend    (virqPend),
  .vinmiPend   (vinmiPend),
  .vfnmiPend   (vfnmiPend),
  .trapOut     (trapOut),
  .illegalOut  (illegalOut),
  .allintState (allintState)
);

// File: tb/virt_irq_status_tb_top.sv
module virt_irq_status_tb_top;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          wrEn = 1'b0;
  logic [1:0]    regSel = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    curLevel = 2'd0;
  logic hypImo = 0, hypFmo = 0, hypVi = 0, hypVf = 0;
  logic extVirq = 0, extVfiq = 0, extVinmi = 0;
  logic physIrq = 0, physFiq = 0, physNmi = 0;

  logic [DW-1:0] rd   [2];
  logic [DW-1:0] stat [2];
  logic          pVirq [2], pVfiq [2], pVinmi [2], pVfnmi [2], oTrap [2], oIll [2];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  virt_irq_status #(.DATA_W(DW), .HAS_NMI(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .curLevel(curLevel), .hypImo(hypImo), .hypFmo(hypFmo), .hypVi(hypVi), .hypVf(hypVf),
    .extVirq(extVirq), .extVfiq(extVfiq), .extVinmi(extVinmi),
    .physIrq(physIrq), .physFiq(physFiq), .physNmi(physNmi),
    .regRdData(rd[0]), .statusWord(stat[0]), .virqPend(pVirq[0]), .vfiqPend(pVfiq[0]),
    .vinmiPend(pVinmi[0]), .vfnmiPend(pVfnmi[0]), .trapOut(oTrap[0]), .illegalOut(oIll[0])
  );

  virt_irq_status #(.DATA_W(DW), .HAS_NMI(1'b0)) dutLegacy_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .wrData(wrData),
    .curLevel(curLevel), .hypImo(hypImo), .hypFmo(hypFmo), .hypVi(hypVi), .hypVf(hypVf),
    .extVirq(extVirq), .extVfiq(extVfiq), .extVinmi(extVinmi),
    .physIrq(physIrq), .physFiq(physFiq), .physNmi(physNmi),
    .regRdData(rd[1]), .statusWord(stat[1]), .virqPend(pVirq[1]), .vfiqPend(pVfiq[1]),
    .vinmiPend(pVinmi[1]), .vfnmiPend(pVfnmi[1]), .trapOut(oTrap[1]), .illegalOut(oIll[1])
  );

  task automatic check(input bit ok, input string tag, input int k,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s dut%0d act=%h exp=%h at %0t", tag, k, act, exp, $time);
    end
  endtask

  // behavioural reference state, index 0 has the feature, index 1 does not
  logic [2:0] mExt [2];
  logic       mAll [2];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 2; k++) begin
        mExt[k] = 3'b000;
        mAll[k] = 1'b0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        if (wrEn && regSel == 2'd0)
          mExt[k] = (k == 0) ? wrData[2:0] : 3'b000;
        if (wrEn && regSel == 2'd1 && k == 0 && curLevel != 2'd0 &&
            !(curLevel == 2'd1 && mExt[k][0] && wrData[13]))
          mAll[k] = wrData[13];
      end
    end
  end

  // per-cycle comparison; R7: lines take effect in the same cycle,
  // register writes from the cycle after their edge
  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < 2; k++) begin
        logic eVirq, eVfiq, eVinmi, eVfnmi, eTrap, eIll;
        logic [DW-1:0] eStat, eRd;
        eVirq  = (hypVi && !mExt[k][1]) || extVirq;
        eVinmi = (hypVi &&  mExt[k][1]) || extVinmi;
        eVfiq  = (hypVf && !mExt[k][2]) || extVfiq;
        eVfnmi =  hypVf &&  mExt[k][2];
        eStat = '0;
        eStat[7]  = hypImo ? (eVirq || eVinmi) : (physIrq || physNmi);
        eStat[10] = hypImo ? eVinmi : physNmi;
        eStat[6]  = hypFmo ? (eVfiq || eVfnmi) : physFiq;
        eStat[9]  = hypFmo ? eVfnmi : 1'b0;
        eRd = '0;
        if (regSel == 2'd0) eRd[2:0] = mExt[k];
        else if (regSel == 2'd1) eRd[13] = mAll[k];
        else if (regSel == 2'd2) eRd = eStat;
        eTrap = (k == 0) && wrEn && regSel == 2'd1 && curLevel == 2'd1 && mExt[k][0] && wrData[13];
        eIll  = (k == 0) && wrEn && regSel == 2'd1 && curLevel == 2'd0;
        check(pVirq[k]  === eVirq,  "R2 virq",  k, DW'(pVirq[k]),  DW'(eVirq));
        check(pVfiq[k]  === eVfiq,  "R3 vfiq",  k, DW'(pVfiq[k]),  DW'(eVfiq));
        check(pVinmi[k] === eVinmi, "R4 vinmi", k, DW'(pVinmi[k]), DW'(eVinmi));
        check(pVfnmi[k] === eVfnmi, "R5 vfnmi", k, DW'(pVfnmi[k]), DW'(eVfnmi));
        check(stat[k] === eStat, (hypImo ? "R8 status" : "R9 status"), k, stat[k], eStat);
        case (regSel)
          2'd0:    check(rd[k] === eRd, "R6 ext read", k, rd[k], eRd);
          2'd1:    check(rd[k] === eRd, "R10 allint read", k, rd[k], eRd);
          default: check(rd[k] === eRd, "R13 status/none read", k, rd[k], eRd);
        endcase
        check(oTrap[k] === eTrap, "R11 trap", k, DW'(oTrap[k]), DW'(eTrap));
        check(oIll[k]  === eIll,  "R12 illegal", k, DW'(oIll[k]), DW'(eIll));
      end
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [DW-1:0] data, input logic [1:0] lvl);
    @(posedge clk); #1;
    wrEn = 1'b1; regSel = sel; wrData = data; curLevel = lvl;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while reset is held
    for (int k = 0; k < 2; k++)
      check({pVirq[k], pVfiq[k], pVinmi[k], pVfnmi[k], rd[k] == '0} === 5'b00001,
            "R1 reset", k, {pVirq[k], pVfiq[k], pVinmi[k], pVfnmi[k]}, '0);
    #1 rstN = 1'b1;

    // R6 and R2..R5 via the model: every extension value under every input combination
    for (int e = 0; e < 8; e++) begin
      regWrite(2'd0, {{(DW-3){1'b1}}, 3'(e)}, 2'd2);
      for (int c = 0; c < 1024; c++) begin
        @(posedge clk); #1;
        {hypImo, hypFmo, hypVi, hypVf, extVirq, extVfiq, extVinmi,
         physIrq, physFiq, physNmi} = 10'(c);
        regSel = 2'(c) ^ 2'(e);
      end
    end

    // R13: status write is ignored
    regWrite(2'd2, '1, 2'd3);
    regWrite(2'd3, '1, 2'd3);

    // R10 R11 R12: ALLINT writes from each level, with and without trap enable
    for (int tr = 0; tr < 2; tr++) begin
      regWrite(2'd0, DW'(tr), 2'd2);
      for (int lvl = 0; lvl < 4; lvl++) begin
        regWrite(2'd1, '0, 2'd2);
        regWrite(2'd1, ~(DW'(1) << 13) | (DW'(1) << 13), 2'(lvl));
        @(posedge clk); #1 regSel = 2'd1;
        regWrite(2'd1, '1 ^ (DW'(1) << 13), 2'(lvl));
        @(posedge clk); #1 regSel = 2'd1;
        regWrite(2'd1, DW'(1) << 13, 2'd3);
        regWrite(2'd1, '0, 2'(lvl));
        @(posedge clk); #1 regSel = 2'd1;
      end
    end

    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule